// File: doc/BRIEF.md
# Stereo Serial Audio Port (I2S / MSB-Justified)

This block is a stereo serial audio port that drives the bit clock and the word-select line as master. Frames of two 16-bit samples enter through a valid/ready stream into a 16-deep transmit FIFO. They leave on the serial data output, first bit first. A deserializer rebuilds frames from the serial input and places them in a 16-deep receive FIFO, which drains through a second valid/ready stream. Each FIFO entry is 32 bits: the left sample is in bits 31:16 and the right sample is in bits 15:0.

A small register file sets the framing (I2S or MSB-justified), internal loopback, the disables for the playback path and the recording path, and the bit-clock divider. A read-only status word reports the two FIFO flags and a 4-bit fill field for each FIFO. The true 5-bit levels are rebuilt from those flags. Two sticky flags, underrun and overrun, are cleared by writing 1 to them.

Stream rules: a transmit word is taken in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low exactly while the transmit FIFO holds 16 words. A receive word leaves in any cycle where `rx_valid` and `rx_ready` are both high. `rx_valid` is high while the receive FIFO is not empty. Holding `rx_ready` low never stalls the serial side: frames that find the receive FIFO full are dropped. The register file uses `cfg_addr` 0 = control, 1 = status, 2 = sticky flags, 3 = divider. Reads are combinational.

Top module: `i2s_audio_port`

## Requirements
- R1: With control bit 0 clear (I2S), left data is sent while `ws_o` is low. Each channel's MSB appears one bit clock after the `ws_o` edge. The right channel's LSB falls in the first bit clock of the next left half.
- R2: With control bit 0 set (MSB-justified), left data is sent while `ws_o` is high. The MSB appears in the same bit clock as the `ws_o` edge.
- R3: With control bit 5 set (loopback), the deserializer takes `sd_o`. With bit 5 clear, it takes `sd_i`.
- R4: Control bit 4 (playback off) takes effect at the next frame start. While it holds, the transmit FIFO is not read, `sd_o` stays 0, and no underrun is flagged.
- R5: Control bit 3 (recording off) takes effect at the next frame start. While it holds, no frame enters the receive FIFO.
- R6: After reset the control word is 0 (I2S, loopback off, both paths on), the divider is 1, and both FIFOs are empty.
- R7: A write to the status address changes neither the status nor the control word.
- R8: Status holds the transmit fill field in bits 3:0 and the transmit-not-full flag in bit 8. {~bit8, bits 3:0} equals the transmit level from 0 to 16.
- R9: Status holds the receive fill field in bits 7:4 and the receive-not-empty flag in bit 9. If the field is 0, the level is {bit9, 4'b0}; otherwise it is the field itself.
- R10: If playback is on and the transmit FIFO is empty at a frame start, a zero frame is sent and flag bit 0 sets. The flag stays set until a write of 1 to that bit.
- R11: A completed frame that finds the receive FIFO full is dropped and flag bit 1 sets. The flag stays set until a write of 1 to that bit, and clearing one flag leaves the other unchanged.
- R12: Both streams keep first-in first-out order. `tx_ready` is low only when the transmit FIFO is full, and `rx_valid` is high only when the receive FIFO holds data.
- R13: Each bit-clock phase lasts divider+1 system clocks. A frame is 32 bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO can accept |
| tx_data | input | 32 | Transmit word {left, right} |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Consumer accepts receive word |
| rx_data | output | 32 | Receive word {left, right} |
| sclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data out, changes after falling bit-clock edges |
| sd_i | input | 1 | Serial data in, sampled on rising bit-clock edges |

## Verification
The hardest state to reach is a receive FIFO that is exactly full while serial frames keep arriving, because it needs sixteen serial frames with the consumer stalled. The stimulus gets there by preloading sixteen words with playback held off, and by holding `rx_ready` low. It then releases both paths in the same frame, so the following underrun frame is the first one dropped. The framing checks decode the pins separately from loopback, because a framing error in loopback would cancel between transmitter and receiver. An inverting external path (`sd_i = ~sd_o`) shows that loopback really selects the source.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  localparam int SAMPLE_W = 16;
  localparam int FRAME_W  = 2 * SAMPLE_W;
  localparam int SLOT_W   = $clog2(FRAME_W);
  localparam int CFG_W    = 16;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam int CB_MSBJ = 0;
  localparam int CB_RDIS = 3;
  localparam int CB_PDIS = 4;
  localparam int CB_LOOP = 5;

  typedef struct packed {
    logic loop;
    logic play_dis;
    logic rec_dis;
    logic msbj;
  } ctrl_t;
endpackage

// File: rtl/i2s_port_fifo.sv
module i2s_port_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [W-1:0]               wr_data,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr_fire, rd_fire;

  assign wr_ready = (cnt != CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_data  = mem[rp];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_fire) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_fire) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: occupancy never exceeds the depth
  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R12: a lone read lowers the level by exactly one
  a_r12_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !wr_fire) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/i2s_port_bclk.sv
module i2s_port_bclk
  import i2s_port_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  output logic              sclk,
  output logic              rise_tick,
  output logic              fall_tick,
  output logic [SLOT_W-1:0] slot
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sclk      <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      slot      <= '1;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (cnt >= half_div) begin
        cnt  <= '0;
        sclk <= ~sclk;
        if (sclk) begin
          fall_tick <= 1'b1;
          slot      <= slot + 1'b1;
        end else begin
          rise_tick <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R13: the two edge strobes never coincide
  a_r13_tick_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
  // R13: every bit-clock fall advances the slot by one, wrapping at 32
  a_r13_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (slot == SLOT_W'($past(slot) + 1'b1)));
  // R13: the bit clock moves only together with an edge strobe
  a_r13_sclk_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> (rise_tick || fall_tick));
endmodule

// File: rtl/i2s_port_tx.sv
module i2s_port_tx
  import i2s_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall_tick,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               msbj,
  input  logic               play_dis,
  input  logic               fifo_valid,
  output logic               fifo_pop,
  input  logic [FRAME_W-1:0] fifo_data,
  output logic               sd,
  output logic               ws,
  output logic               underrun
);
  logic [FRAME_W-1:0] frame_q, word_now;
  logic               b_prev, bit_now, frame_start;

  assign frame_start = fall_tick && (slot == '0);
  assign fifo_pop    = frame_start && !play_dis && fifo_valid;
  assign underrun    = frame_start && !play_dis && !fifo_valid;

  always_comb begin
    word_now = frame_q;
    if (frame_start) word_now = fifo_pop ? fifo_data : '0;
    bit_now = word_now[SLOT_W'(FRAME_W - 1) - slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      b_prev  <= 1'b0;
      sd      <= 1'b0;
      ws      <= 1'b0;
    end else if (fall_tick) begin
      frame_q <= word_now;
      b_prev  <= bit_now;
      sd      <= msbj ? bit_now : b_prev;
      ws      <= slot[SLOT_W-1] ^ msbj;
    end
  end

  // R1: word select moves only right after a bit-clock fall
  a_r1_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $past(fall_tick));
  // R2: serial data moves only right after a bit-clock fall
  a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $past(fall_tick));
  // R4: with playback off the FIFO is never read
  a_r4_no_pop_off: assert property (@(posedge clk) disable iff (!rst_n)
    play_dis |-> !(fifo_pop || underrun));
endmodule

// File: rtl/i2s_port_rx.sv
module i2s_port_rx
  import i2s_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               msbj,
  input  logic               rec_dis,
  input  logic               din,
  output logic               push_valid,
  output logic [FRAME_W-1:0] push_data,
  input  logic               fifo_ready,
  output logic               overrun
);
  logic [FRAME_W-1:0] shift;
  logic [SLOT_W-1:0]  pos;
  logic               rec_q, armed, done;

  assign pos  = msbj ? slot : slot - 1'b1;
  assign done = rise_tick && (pos == SLOT_W'(FRAME_W - 1)) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift      <= '0;
      rec_q      <= 1'b0;
      armed      <= 1'b0;
      push_valid <= 1'b0;
      push_data  <= '0;
      overrun    <= 1'b0;
    end else begin
      push_valid <= done && fifo_ready;
      overrun    <= done && !fifo_ready;
      if (fall_tick && (slot == '0)) rec_q <= !rec_dis;
      if (rise_tick) begin
        shift <= {shift[FRAME_W-2:0], din};
        if (pos == '0) armed <= rec_q;
        if (pos == SLOT_W'(FRAME_W - 1)) armed <= 1'b0;
      end
      if (done) push_data <= {shift[FRAME_W-2:0], din};
    end
  end

  // R11: a frame is written only when the FIFO had room
  a_r11_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> fifo_ready);
  // R5: a write or drop always follows a frame that was armed
  a_r5_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || overrun) |-> $past(armed));
endmodule

// File: rtl/i2s_audio_port.sv
module i2s_audio_port
  import i2s_port_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_data,
  output logic               sclk_o,
  output logic               ws_o,
  output logic               sd_o,
  input  logic               sd_i
);
  localparam int LW = $clog2(DEPTH);

  ctrl_t              ctrl_q;
  logic [DIV_W-1:0]   div_q;
  logic               flag_ur, flag_ov;
  logic               rise_tick, fall_tick;
  logic [SLOT_W-1:0]  slot;
  logic               txf_valid, txf_pop, ur_pulse, ov_pulse;
  logic [FRAME_W-1:0] txf_data, push_data;
  logic               push_valid, rxf_wr_ready, rx_din;
  logic [LW:0]        tx_level, rx_level;
  logic [CFG_W-1:0]   stat_word;
  logic               wr_ctrl, wr_flags, wr_div;

  assign wr_ctrl  = cfg_we && (cfg_addr == ADDR_CTRL);
  assign wr_flags = cfg_we && (cfg_addr == ADDR_FLAGS);
  assign wr_div   = cfg_we && (cfg_addr == ADDR_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
      flag_ur <= 1'b0;
      flag_ov <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.msbj     <= cfg_wdata[CB_MSBJ];
        ctrl_q.rec_dis  <= cfg_wdata[CB_RDIS];
        ctrl_q.play_dis <= cfg_wdata[CB_PDIS];
        ctrl_q.loop     <= cfg_wdata[CB_LOOP];
      end
      if (wr_div) div_q <= cfg_wdata[DIV_W-1:0];
      flag_ur <= ur_pulse || (flag_ur && !(wr_flags && cfg_wdata[0]));
      flag_ov <= ov_pulse || (flag_ov && !(wr_flags && cfg_wdata[1]));
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[LW-1:0]    = tx_level[LW-1:0];
    stat_word[2*LW-1:LW] = rx_level[LW-1:0];
    stat_word[2*LW]      = (tx_level != (LW+1)'(DEPTH));
    stat_word[2*LW+1]    = (rx_level != '0);
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_CTRL: begin
        cfg_rdata[CB_MSBJ] = ctrl_q.msbj;
        cfg_rdata[CB_RDIS] = ctrl_q.rec_dis;
        cfg_rdata[CB_PDIS] = ctrl_q.play_dis;
        cfg_rdata[CB_LOOP] = ctrl_q.loop;
      end
      ADDR_STAT:  cfg_rdata = stat_word;
      ADDR_FLAGS: cfg_rdata[1:0] = {flag_ov, flag_ur};
      default:    cfg_rdata[DIV_W-1:0] = div_q;
    endcase
  end

  assign rx_din = ctrl_q.loop ? sd_o : sd_i;

  i2s_port_bclk #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .half_div(div_q), .sclk(sclk_o),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .slot(slot)
  );

  i2s_port_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .wr_valid(tx_valid), .wr_ready(tx_ready),
    .wr_data(tx_data), .rd_valid(txf_valid), .rd_ready(txf_pop),
    .rd_data(txf_data), .level(tx_level)
  );

  i2s_port_tx u_tx (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .slot(slot),
    .msbj(ctrl_q.msbj), .play_dis(ctrl_q.play_dis), .fifo_valid(txf_valid),
    .fifo_pop(txf_pop), .fifo_data(txf_data), .sd(sd_o), .ws(ws_o),
    .underrun(ur_pulse)
  );

  i2s_port_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .slot(slot), .msbj(ctrl_q.msbj), .rec_dis(ctrl_q.rec_dis), .din(rx_din),
    .push_valid(push_valid), .push_data(push_data), .fifo_ready(rxf_wr_ready),
    .overrun(ov_pulse)
  );

  i2s_port_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .wr_valid(push_valid), .wr_ready(rxf_wr_ready),
    .wr_data(push_data), .rd_valid(rx_valid), .rd_ready(rx_ready),
    .rd_data(rx_data), .level(rx_level)
  );

  // R7: a status write leaves the control word untouched
  a_r7_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_STAT) |=> $stable(ctrl_q));
  // R10: the underrun flag holds until cleared by a 1
  a_r10_ur_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ur && !(wr_flags && cfg_wdata[0])) |=> flag_ur);
  // R11: the overrun flag holds until cleared by a 1
  a_r11_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ov && !(wr_flags && cfg_wdata[1])) |=> flag_ov);
  // R11: a drop sets the overrun flag on the next cycle
  a_r11_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
    ov_pulse |=> flag_ov);
endmodule

// File: tb/i2s_audio_port_tb.sv
`timescale 1ns/1ps
module i2s_audio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [31:0] rx_data;
  logic        sclk_o, ws_o, sd_o, sd_i;

  always #4 clk = ~clk;
  assign sd_i = ~sd_o;

  i2s_audio_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .sclk_o(sclk_o), .ws_o(ws_o),
    .sd_o(sd_o), .sd_i(sd_i)
  );

  localparam logic [15:0] C_MSB = 16'h01, C_RD = 16'h08, C_PD = 16'h10, C_LOOP = 16'h20;

  logic [31:0] expq[$];
  logic [31:0] pinq[$];
  int          checks = 0, errors = 0, div_b = 1, sd_ones = 0;
  logic [31:0] inv_mask = '0, idle_word = '1, pw = '0;
  bit          msbj_b = 1'b0, psclk = 1'b0, pws = 1'b0, done = 1'b0;
  int          bp = -1;
  longint      cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // scoreboard monitor and pin-level frame decoder
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_ready) begin
        if (expq.size() > 0) chk("R12 rx stream order", rx_data, expq.pop_front());
        else chk("R10 idle frame content", rx_data, idle_word);
      end
      sd_ones += int'(sd_o);
      if (sclk_o && !psclk) begin
        if (msbj_b && ws_o && !pws) bp = 0;
        if (bp >= 0 && bp < 32) begin
          pw[31-bp] = sd_o;
          if (bp == 31 && pw != 0) begin
            if (pinq.size() > 0)
              chk(msbj_b ? "R2 msb-justified pin frame" : "R1 i2s pin frame", pw, pinq.pop_front());
            else chk("R1 unexpected pin frame", pw, 32'h0);
          end
          bp++;
        end
        if (!msbj_b && !ws_o && pws) bp = 0;
        pws = ws_o;
      end
      psclk = sclk_o;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    cfg_addr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic set_ctrl(input logic [15:0] v);
    msbj_b = v[0];
    wr(2'd0, v);
  endtask

  task automatic push_tx(input logic [31:0] w, input bit to_rx);
    @(posedge clk); #1;
    tx_data = w; tx_valid = 1'b1;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1;
    tx_valid = 1'b0;
    if (to_rx) expq.push_back(w ^ inv_mask);
    pinq.push_back(w);
  endtask

  task automatic wait_frames(input int n);
    repeat (n * 64 * (div_b + 1)) @(posedge clk);
  endtask

  task automatic measure(output longint p);
    longint t0;
    wait (sclk_o == 1'b0); wait (sclk_o == 1'b1); t0 = cyc;
    wait (sclk_o == 1'b0); wait (sclk_o == 1'b1); p = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    longint per;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    rd(2'd0, v); chk("R6 control after reset", 32'(v), 32'h0);
    rd(2'd3, v); chk("R6 divider after reset", 32'(v), 32'h1);
    rd(2'd1, v); chk("R6 status after reset, fifos empty", 32'(v), 32'h100);

    // quiesce, then switch to loopback with both paths held off
    set_ctrl(C_PD | C_RD); wait_frames(2);
    set_ctrl(C_LOOP | C_PD | C_RD); wait_frames(2);
    idle_word = '0;
    wr(2'd2, 16'h3);
    rd(2'd2, v); chk("R10 flags cleared by writing ones", 32'(v), 32'h0);

    // fill levels with playback off
    for (int i = 0; i < 5; i++) push_tx(32'hA100_0001 + 32'(i) * 32'h0103_0507, 1'b1);
    rd(2'd1, v); chk("R8 tx level 5 encoding", 32'(v), 32'h105);
    for (int i = 5; i < 16; i++) push_tx(32'hA100_0001 + 32'(i) * 32'h0103_0507, 1'b1);
    @(negedge clk); chk("R12 tx_ready low when full", 32'(tx_ready), 32'h0);
    rd(2'd1, v); chk("R8 tx level 16 encoding", 32'(v), 32'h000);
    sd_ones = 0;
    wait_frames(2);
    chk("R4 sd_o quiet while playback off", 32'(sd_ones), 32'h0);
    rd(2'd1, v); chk("R4 tx fifo untouched while off", 32'(v), 32'h000);
    rd(2'd2, v); chk("R4 no underrun while off", 32'(v), 32'h0);

    // I2S loopback run
    set_ctrl(C_LOOP);
    wait_frames(20);
    chk("R1 all loopback words received", 32'(expq.size()), 32'h0);
    rd(2'd2, v); chk("R10 underrun flagged, no overrun", 32'(v), 32'h1);

    // MSB-justified loopback run
    set_ctrl(C_LOOP | C_PD | C_RD); wait_frames(2);
    set_ctrl(C_LOOP | C_MSB | C_PD | C_RD); wait_frames(2);
    wr(2'd2, 16'h3);
    for (int i = 0; i < 8; i++) push_tx(32'h5A00_C3F0 ^ (32'(i) << 9) ^ 32'(i + 1), 1'b1);
    set_ctrl(C_LOOP | C_MSB);
    wait_frames(12);
    chk("R2 all msb-justified words received", 32'(expq.size()), 32'h0);

    // recording off while playing
    set_ctrl(C_LOOP | C_MSB | C_RD);
    for (int i = 0; i < 3; i++) push_tx(32'h0F0F_1234 + 32'(i), 1'b0);
    wait_frames(6);
    @(negedge clk); chk("R5 nothing received while recording off", 32'(rx_valid), 32'h0);
    rd(2'd1, v); chk("R5 rx empty while recording off", 32'(v), 32'h100);

    // external input path, inverted by the bench
    set_ctrl(C_PD | C_RD); wait_frames(2);
    inv_mask = '1; idle_word = '1;
    for (int i = 0; i < 6; i++) push_tx(32'h1357_9BDF + 32'(i) * 32'h0011_0101, 1'b1);
    set_ctrl(16'h0);
    wait_frames(10);
    chk("R3 external path words received", 32'(expq.size()), 32'h0);

    // overrun with a stalled consumer
    set_ctrl(C_PD | C_RD); wait_frames(2);
    set_ctrl(C_LOOP | C_PD | C_RD); wait_frames(2);
    inv_mask = '0; idle_word = '0;
    @(posedge clk); #1; rx_ready = 1'b0;
    for (int i = 0; i < 16; i++) push_tx(32'hC0DE_0000 + 32'(i) * 32'h0101_0011, 1'b1);
    wr(2'd2, 16'h3);
    set_ctrl(C_LOOP);
    wait_frames(20);
    rd(2'd1, v); chk("R9 rx level 16 encoding", 32'(v), 32'h300);
    rd(2'd2, v); chk("R11 overrun and underrun flagged", 32'(v), 32'h3);
    set_ctrl(C_LOOP | C_PD | C_RD); wait_frames(2);
    wr(2'd2, 16'h2);
    rd(2'd2, v); chk("R11 overrun cleared alone", 32'(v), 32'h1);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R7 status ignores writes", 32'(v), 32'h300);
    rd(2'd0, v); chk("R7 control unchanged by status write", 32'(v), 32'(C_LOOP | C_PD | C_RD));
    @(posedge clk); #1; rx_ready = 1'b1;
    repeat (40) @(posedge clk);
    chk("R11 first 16 frames kept in order", 32'(expq.size()), 32'h0);
    rd(2'd1, v); chk("R9 rx empty after drain", 32'(v), 32'h100);

    // bit-clock divider
    measure(per); chk("R13 bit period at divider 1", 32'(per), 32'd4);
    wr(2'd3, 16'h3); div_b = 3;
    repeat (20) @(posedge clk);
    measure(per); chk("R13 bit period at divider 3", 32'(per), 32'd8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule